// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block is an 8-bit up-counter that can serve either as a periodic interval timer or as a watchdog. Software chooses one of eight prescaler taps as the count rate, turns counting on and off, and picks the behaviour on wrap-around. In interval mode, a wrap from 0xFF to 0x00 sets a sticky overflow flag, and that flag drives the interrupt request line. In watchdog mode, the same wrap sends a fixed-length active-low pulse on an external pin and leaves the flag untouched.

Software reaches two byte-wide registers over a small synchronous bus. The select input picks the register: select 0 is the count, select 1 is control/status. Control/status layout: bit 7 overflow flag, bit 6 mode (0 interval, 1 watchdog), bit 5 run enable, bits 4 and 3 read as 1 and ignore writes, bits 2..0 tap select. Read data appears one cycle after the read strobe, qualified by a valid pulse. The overflow flag cannot be set by software. Software can clear it in two ways: write a 0 to it after having read it as 1, or stop the timer while in interval mode.

Top module: `wit_timer`

## Requirements
- R1: After reset, the count reads 0x00, control/status reads 0x18, the interrupt request is low and the watchdog output is high.
- R2: While the run enable (bit 5) is 0, the count holds any written value.
- R3: While running, the count advances once per 2^k clocks, where k is 1, 6, 7, 9, 11, 13, 15, 17 for select codes 0..7. The first increment comes 2^k clocks after the enabling write.
- R4: In interval mode a wrap from 0xFF to 0x00 sets the overflow flag (bit 7), and the interrupt request follows the flag.
- R5: In watchdog mode a wrap leaves the flag at 0 and drives the watchdog output low for exactly 8 clocks.
- R6: A control/status write with bit 7 = 0, made while the flag has not been read as 1 since it was set, leaves the flag at 1.
- R7: A control/status write with bit 7 = 0, made after a read that returned the flag as 1, clears the flag and drops the interrupt request.
- R8: Writing 1 to bit 7 never sets or clears the flag.
- R9: In interval mode, writing 0 to the run enable clears the flag.
- R10: When a count write and an increment fall in the same cycle, the written value is stored.
- R11: Bits 4 and 3 of control/status always read as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register select: 0 count, 1 control/status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | One-cycle pulse one clock after a read strobe |
| irq_interval | output | 1 | Interval interrupt request, level of the overflow flag |
| wdt_ovf_n | output | 1 | Active-low watchdog overflow pulse |

## Verification
Two situations are hardest to reach from the ports. The first is an increment landing in the same cycle as a count write. The second is the flag clear that depends on an earlier read, since a plain write must not clear the flag. The bench records the clock edge of the enabling write and idles until the next tap pulse is due, then times the count write onto that edge. It reaches the flag states in order: it raises the flag by preloading 0xFE, writes a 0 without reading, then reads, then writes again. Between steps it moves to the slowest tap so that no further wrap interferes.

// File: rtl/wit_pkg.sv
// Package: shared constants and helpers for the dual-mode timer.
// Assumes a byte-wide register bus and an 8-code tap select.
package wit_pkg;
    localparam int DATA_W    = 8;
    localparam int SEL_W     = 3;
    localparam int NUM_TAPS  = 1 << SEL_W;
    localparam int PULSE_LEN = 8;

    // Control/status bit positions (decoded by software, so fixed).
    localparam int BIT_FLAG = 7;
    localparam int BIT_MODE = 6;
    localparam int BIT_RUN  = 5;

    // log2 of the prescaler divide ratio for each select code.
    function automatic int tap_shift(input int code);
        case (code)
            0:       return 1;
            1:       return 6;
            2:       return 7;
            3:       return 9;
            4:       return 11;
            5:       return 13;
            6:       return 15;
            default: return 17;
        endcase
    endfunction

    localparam int PRE_W = tap_shift(NUM_TAPS - 1);

    typedef struct packed {
        logic             flag;
        logic             mode;
        logic             run;
        logic [SEL_W-1:0] sel;
    } csr_t;
endpackage

// File: rtl/wit_prescaler.sv
// Prescaler: free-running divider held at zero while stopped; emits a
// one-cycle tick when the selected tap's low bits are all ones.
// Assumes sel may change at any time; a tick is never two cycles long.
module wit_prescaler
    import wit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0]    pre_q;
    logic [NUM_TAPS-1:0] tap_hit;

    // Divider: counts while running, cleared when stopped or in reset.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pre_q <= '0;
        else                pre_q <= pre_q + PRE_W'(1);
    end

    // One tap detector per select code.
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int SH = tap_shift(g);
        assign tap_hit[g] = &pre_q[SH-1:0];
    end

    // Tick only while running, from the chosen tap.
    assign tick = run && tap_hit[sel];

    // R3: a tick is followed by a cycle with no tick, for every tap.
    a_r3_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wit_counter.sv
// Counter: the software-visible up-counter. A bus write takes priority
// over an increment in the same cycle; wrap from all-ones is reported.
module wit_counter
    import wit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] count,
    output logic              wrap
);
    localparam logic [DATA_W-1:0] TOP = '1;

    // Wrap event: an increment from the top value that is not overridden.
    assign wrap = tick && !wr && (count == TOP);

    // Count register: write first, then increment.
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (wr)   count <= wdata;
        else if (tick) count <= count + DATA_W'(1);
    end

    // R10: a write is stored even when an increment is due.
    a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> count == $past(wdata));
    // R2: with no tick and no write the count holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr) |=> $stable(count));
    // R4: a reported wrap leaves the count at zero.
    a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> count == '0);
endmodule

// File: rtl/wit_ctrl.sv
// Control/status: mode, run and tap fields plus the sticky overflow flag
// with its read-before-clear rule. Assumes at most one bus access per cycle.
module wit_ctrl
    import wit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wrap,
    output csr_t              csr
);
    logic armed_q;
    logic set_flag, clr_sw, clr_stop, flag_d;

    assign set_flag = wrap && !csr.mode;
    assign clr_sw   = wr && !wdata[BIT_FLAG] && armed_q;
    assign clr_stop = wr && !wdata[BIT_RUN] && !csr.mode;

    // Next flag: setting wins over any clear in the same cycle.
    always_comb begin
        if (set_flag)               flag_d = 1'b1;
        else if (clr_sw || clr_stop) flag_d = 1'b0;
        else                        flag_d = csr.flag;
    end

    // Field registers: software writes mode, run and tap select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr.mode <= 1'b0;
            csr.run  <= 1'b0;
            csr.sel  <= '0;
        end else if (wr) begin
            csr.mode <= wdata[BIT_MODE];
            csr.run  <= wdata[BIT_RUN];
            csr.sel  <= wdata[SEL_W-1:0];
        end
    end

    // Flag register and its read-as-one marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr.flag <= 1'b0;
            armed_q  <= 1'b0;
        end else begin
            csr.flag <= flag_d;
            if (!flag_d)              armed_q <= 1'b0;
            else if (rd && csr.flag)  armed_q <= 1'b1;
        end
    end

    // R4: an interval-mode wrap sets the flag.
    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !csr.mode) |=> csr.flag);
    // R5: in watchdog mode a clear flag stays clear.
    a_r5_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (csr.mode && !csr.flag) |=> !csr.flag);
    // R6: without a prior read, writing 0 keeps the flag (run kept on).
    a_r6_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        (csr.flag && wr && !armed_q && wdata[BIT_RUN]) |=> csr.flag);
    // R7: after a read of 1, writing 0 clears it unless a wrap sets it again.
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !wdata[BIT_FLAG] && armed_q && !wrap) |=> !csr.flag);
endmodule

// File: rtl/wit_pulse.sv
// Pulse stretcher: turns a one-cycle start into an active-low output of
// LEN clocks; a new start restarts the pulse.
module wit_pulse #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic out_n
);
    localparam int PW = $clog2(LEN + 1);
    logic [PW-1:0] left_q;

    // Remaining-length counter.
    always_ff @(posedge clk) begin
        if (!rst_n)            left_q <= '0;
        else if (start)        left_q <= PW'(LEN);
        else if (left_q != '0) left_q <= left_q - PW'(1);
    end

    assign out_n = (left_q == '0);

    // R5: a start drives the output low on the next cycle.
    a_r5_pulse_low: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !out_n);
    // R5: the output returns high only from the last count.
    a_r5_pulse_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_n) |-> $past(left_q) == PW'(1));
endmodule

// File: rtl/wit_timer.sv
// Top: dual-mode watchdog / interval timer with a byte register bus.
// Assumes bus_wr and bus_rd are not asserted together.
module wit_timer
    import wit_pkg::*;
#(
    parameter int PULSE_CLKS = PULSE_LEN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              irq_interval,
    output logic              wdt_ovf_n
);
    csr_t              csr;
    logic              tick, wrap;
    logic [DATA_W-1:0] count;
    logic [DATA_W-1:0] csr_byte;
    logic              wire_unused;

    assign wire_unused = ^bus_wdata[4:3];

    wit_prescaler u_pre (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (csr.run),
        .sel  (csr.sel),
        .tick (tick)
    );

    wit_counter u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .wr   (bus_wr && !bus_sel),
        .wdata(bus_wdata),
        .count(count),
        .wrap (wrap)
    );

    wit_ctrl u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .wr   (bus_wr && bus_sel),
        .rd   (bus_rd && bus_sel),
        .wdata(bus_wdata),
        .wrap (wrap),
        .csr  (csr)
    );

    wit_pulse #(.LEN(PULSE_CLKS)) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .start(wrap && csr.mode),
        .out_n(wdt_ovf_n)
    );

    assign csr_byte     = {csr.flag, csr.mode, csr.run, 2'b11, csr.sel};
    assign irq_interval = csr.flag;

    // Read port: registered data and valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) bus_rdata <= bus_sel ? csr_byte : count;
        end
    end

    // R11: control/status reads always carry ones in bits 4 and 3.
    a_r11_fixed_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_sel) |=> bus_rdata[4:3] == 2'b11);
endmodule

// File: tb/tb_wit_timer.sv
module tb_wit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       bus_rvalid, irq_interval, wdt_ovf_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int en_e = 0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sb[$];

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wit_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq_interval(irq_interval),
        .wdt_ovf_n(wdt_ovf_n)
    );

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // Driver: called at a negedge; the write lands on edge cyc+1.
    task automatic bus_write(input logic sel, input logic [7:0] d);
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = d;
        if (sel && d[5]) en_e = cyc + 1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Driver: pushes the expected read item into the scoreboard.
    task automatic bus_read(input logic sel, input logic [7:0] exp, input string tag);
        item_t it;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        bus_sel = sel; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares each returned read against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (sb.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: actual 0x%02h expected no read", bus_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, bus_rdata, it.exp);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lows;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11: reset state.
        check("R1 irq", {7'd0, irq_interval}, 8'h00);
        check("R1 wdt", {7'd0, wdt_ovf_n}, 8'h01);
        bus_read(1'b0, 8'h00, "R1 count");
        bus_read(1'b1, 8'h18, "R1 R11 csr");

        // R2: stopped counter holds a written value.
        bus_write(1'b0, 8'h33);
        idle(20);
        bus_read(1'b0, 8'h33, "R2 hold");

        // R3: tap code 0 (every 2 clocks).
        bus_write(1'b0, 8'h00);
        bus_write(1'b1, 8'h20);
        bus_read(1'b0, 8'((cyc - en_e) / 2), "R3 tap0 early");
        idle(13);
        bus_read(1'b0, 8'((cyc - en_e) / 2), "R3 tap0");
        bus_write(1'b1, 8'h00);

        // R3: tap code 1 (every 64 clocks).
        bus_write(1'b0, 8'h00);
        bus_write(1'b1, 8'h21);
        idle(200);
        bus_read(1'b0, 8'((cyc - en_e) / 64), "R3 tap1");
        bus_write(1'b1, 8'h00);

        // R4: interval wrap from 0xFE sets the flag.
        bus_write(1'b0, 8'hFE);
        bus_write(1'b1, 8'h20);
        idle(8);
        check("R4 irq", {7'd0, irq_interval}, 8'h01);
        bus_read(1'b0, 8'(8'hFE + (cyc - en_e) / 2), "R4 count wrapped");
        // R6: write 0 without a prior read; slowest tap stops further wraps.
        bus_write(1'b1, 8'h27);
        check("R6 irq kept", {7'd0, irq_interval}, 8'h01);
        bus_read(1'b1, 8'hBF, "R6 flag kept");
        // R8: writing 1 changes nothing.
        bus_write(1'b1, 8'hA7);
        bus_read(1'b1, 8'hBF, "R8 flag unchanged");
        // R7: read done, now write 0 clears.
        bus_write(1'b1, 8'h27);
        check("R7 irq low", {7'd0, irq_interval}, 8'h00);
        bus_read(1'b1, 8'h3F, "R7 flag cleared");

        // R9: stopping in interval mode clears the flag.
        bus_write(1'b1, 8'h00);
        bus_write(1'b0, 8'hFF);
        bus_write(1'b1, 8'h20);
        idle(4);
        check("R9 irq set", {7'd0, irq_interval}, 8'h01);
        bus_write(1'b1, 8'h00);
        check("R9 irq low", {7'd0, irq_interval}, 8'h00);
        bus_read(1'b1, 8'h18, "R9 csr");

        // R5: watchdog wrap gives an 8-clock low pulse and no flag.
        bus_write(1'b0, 8'hFF);
        bus_write(1'b1, 8'h60);
        lows = 0;
        for (int i = 0; i < 20; i++) begin
            if (!wdt_ovf_n) lows++;
            @(negedge clk);
        end
        check("R5 pulse length", 8'(lows), 8'd8);
        check("R5 irq", {7'd0, irq_interval}, 8'h00);
        bus_read(1'b1, 8'h78, "R5 no flag");
        bus_write(1'b1, 8'h00);

        // R10: count write on the same edge as an increment.
        bus_write(1'b0, 8'h00);
        bus_write(1'b1, 8'h20);
        while (cyc + 1 != en_e + 2) @(negedge clk);
        bus_write(1'b0, 8'h55);
        bus_read(1'b0, 8'h55, "R10 write wins");
        bus_write(1'b1, 8'h00);

        idle(4);
        if (sb.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule